// File: doc/BRIEF.md
# Register Rename Map with Flush and Snapshot Recovery

This block keeps, for every architectural register, a flag and a reorder-buffer slot number. When the flag is set, the newest in-flight micro-operation that writes the register is the one held in that slot, and consumers take the operand from the reorder buffer. When the flag is clear, no in-flight operation writes the register, and the architectural register file holds the current value.

Each cycle one micro-operation is renamed. The block looks up its two source registers from the stored state. If the operation has a destination, that register is pointed at the newly allocated slot. A retire port drops a mapping when its producer leaves the reorder buffer, but only when the mapping still names that producer. Recovery from misspeculation takes one of two forms. A flush, raised once the offending operation has retired, clears every flag. A restore reloads a whole-table snapshot that was saved earlier into one of a small number of slots.

Top module: `rename_table`

## Requirements
- R1: After a cycle with rst_n low, every register reads as unmapped (valid 0, index 0), and every snapshot slot holds an all-unmapped table.
- R2: Each source port returns the flag and slot number currently stored for the selected register, combinationally. When the flag is 0, the index output is 0.
- R3: A rename with ren_valid=1 and ren_dst_we=1 maps ren_dst to {valid 1, ren_rob_idx} from the next cycle on. With ren_dst_we=0, no mapping changes.
- R4: Source lookups in the cycle of a rename return the mapping from before that rename, even when a source equals the destination.
- R5: A retire clears the flag of cmt_dst only when that register is mapped and its stored index equals cmt_rob_idx. Otherwise it has no effect.
- R6: When a rename and a retire name the same register in one cycle, the rename's new mapping is kept.
- R7: flush=1 clears every flag in the next cycle. It discards a rename, a retire and a restore issued in the same cycle.
- R8: ckpt_save=1 stores into slot ckpt_save_slot the table as it stands after this cycle's updates. ckpt_restore=1 (without flush) replaces the whole table with slot ckpt_restore_slot in the next cycle, and overrides any rename or retire issued in the same cycle.
- R9: A save and a restore in the same cycle are independent. The saved slot receives the restored table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ren_valid | input | 1 | A micro-operation is renamed this cycle |
| ren_dst_we | input | 1 | The renamed operation writes a destination |
| ren_src_a | input | AREG_W | First source register |
| ren_src_b | input | AREG_W | Second source register |
| ren_dst | input | AREG_W | Destination register |
| ren_rob_idx | input | ROB_W | Reorder-buffer slot allocated to the operation |
| src_a_valid | output | 1 | First source is produced in flight |
| src_a_idx | output | ROB_W | Producer slot of first source (0 when unmapped) |
| src_b_valid | output | 1 | Second source is produced in flight |
| src_b_idx | output | ROB_W | Producer slot of second source (0 when unmapped) |
| cmt_valid | input | 1 | An operation retires this cycle |
| cmt_dst | input | AREG_W | Destination register of the retiring operation |
| cmt_rob_idx | input | ROB_W | Slot of the retiring operation |
| flush | input | 1 | Clear every mapping |
| ckpt_save | input | 1 | Save the updated table into a slot |
| ckpt_save_slot | input | SLOT_W | Slot written by a save |
| ckpt_restore | input | 1 | Reload the table from a slot |
| ckpt_restore_slot | input | SLOT_W | Slot read by a restore |

## Verification
A rename can land in the same cycle as a retire, a flush or a restore. Each of these collisions decides which mapping survives. The bench raises each pair together on one register. Examples are a retire of the old producer while a new one is renamed, and a flush or restore alongside a rename of a fresh register. It then reads that register back on the next cycle and compares it with a model that applies the stated priority: flush, then restore, then rename, then retire. A pseudo-random phase mixes all four operations and keeps the same comparison running.

// File: rtl/rt_pkg.sv
// Package rt_pkg
// Shared decision type and priority function for the rename map.
// Assumes: one update source is chosen per entry per cycle.
package rt_pkg;

    typedef enum logic [2:0] {
        UPD_HOLD,
        UPD_CLEAR,
        UPD_MAP,
        UPD_LOAD,
        UPD_FLUSH
    } rt_upd_e;

    // Pick the winning update for one entry: flush > restore > rename > retire.
    function automatic rt_upd_e rt_pick(input logic do_flush, input logic do_load,
                                        input logic do_map, input logic do_clear);
        if (do_flush) return UPD_FLUSH;
        if (do_load)  return UPD_LOAD;
        if (do_map)   return UPD_MAP;
        if (do_clear) return UPD_CLEAR;
        return UPD_HOLD;
    endfunction

endpackage

// File: rtl/rt_map_store.sv
// Module rt_map_store
// Holds the live map: one flag and one reorder-buffer index per register.
// Computes the next table from rename, retire, restore and flush requests
// and exposes both the current and the next table.
// Assumes: register IDs beyond NUM_AREGS match no entry.
module rt_map_store
    import rt_pkg::*;
#(
    parameter int NUM_AREGS = 16,
    parameter int ROB_W     = 5,
    localparam int AREG_W   = (NUM_AREGS > 1) ? $clog2(NUM_AREGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ren_we,
    input  logic [AREG_W-1:0] ren_dst,
    input  logic [ROB_W-1:0]  ren_rob_idx,
    input  logic              cmt_valid,
    input  logic [AREG_W-1:0] cmt_dst,
    input  logic [ROB_W-1:0]  cmt_rob_idx,
    input  logic              flush,
    input  logic              restore,
    input  logic              load_valid [NUM_AREGS],
    input  logic [ROB_W-1:0]  load_idx   [NUM_AREGS],
    output logic              cur_valid  [NUM_AREGS],
    output logic [ROB_W-1:0]  cur_idx    [NUM_AREGS],
    output logic              nxt_valid  [NUM_AREGS],
    output logic [ROB_W-1:0]  nxt_idx    [NUM_AREGS]
);

    logic             valid_q [NUM_AREGS];
    logic [ROB_W-1:0] idx_q   [NUM_AREGS];
    logic [NUM_AREGS-1:0] valid_vec;

    // Next-state table: decide the winning update for every entry.
    always_comb begin
        for (int r = 0; r < NUM_AREGS; r++) begin
            logic    map_hit;
            logic    clr_hit;
            rt_upd_e upd;
            map_hit = ren_we && (ren_dst == AREG_W'(r));
            clr_hit = cmt_valid && (cmt_dst == AREG_W'(r)) && valid_q[r]
                      && (idx_q[r] == cmt_rob_idx);
            upd = rt_pick(flush, restore, map_hit, clr_hit);
            nxt_valid[r] = valid_q[r];
            nxt_idx[r]   = idx_q[r];
            case (upd)
                UPD_FLUSH: nxt_valid[r] = 1'b0;
                UPD_LOAD: begin
                    nxt_valid[r] = load_valid[r];
                    nxt_idx[r]   = load_idx[r];
                end
                UPD_MAP: begin
                    nxt_valid[r] = 1'b1;
                    nxt_idx[r]   = ren_rob_idx;
                end
                UPD_CLEAR: nxt_valid[r] = 1'b0;
                default: ;
            endcase
        end
    end

    // State register with synchronous reset to an all-unmapped table.
    always_ff @(posedge clk) begin
        for (int r = 0; r < NUM_AREGS; r++) begin
            if (!rst_n) begin
                valid_q[r] <= 1'b0;
                idx_q[r]   <= '0;
            end else begin
                valid_q[r] <= nxt_valid[r];
                idx_q[r]   <= nxt_idx[r];
            end
        end
    end

    // Drive the current table outputs and a packed flag view.
    always_comb begin
        for (int r = 0; r < NUM_AREGS; r++) begin
            cur_valid[r] = valid_q[r];
            cur_idx[r]   = idx_q[r];
            valid_vec[r] = valid_q[r];
        end
    end

    // R7: a flush leaves every flag clear.
    a_r7_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_vec == '0));

    // R3: an undisturbed rename installs the new mapping.
    a_r3_rename_maps: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_we && !flush && !restore) |=>
            (valid_q[$past(ren_dst)] && (idx_q[$past(ren_dst)] == $past(ren_rob_idx))));

    // R5: retire of the matching producer clears the flag.
    a_r5_retire_match: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_valid && valid_q[cmt_dst] && (idx_q[cmt_dst] == cmt_rob_idx)
         && !(ren_we && ren_dst == cmt_dst) && !flush && !restore)
        |=> !valid_q[$past(cmt_dst)]);

    // R5: retire of a stale producer leaves the entry alone.
    a_r5_retire_stale: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_valid && (idx_q[cmt_dst] != cmt_rob_idx)
         && !(ren_we && ren_dst == cmt_dst) && !flush && !restore)
        |=> (valid_q[$past(cmt_dst)] == $past(valid_q[cmt_dst])));

endmodule

// File: rtl/rt_read_port.sv
// Module rt_read_port
// One combinational source lookup. Returns the flag and the index, with
// the index forced to zero for an unmapped register.
// Assumes: out-of-range register IDs read as unmapped.
module rt_read_port #(
    parameter int NUM_AREGS = 16,
    parameter int ROB_W     = 5,
    localparam int AREG_W   = (NUM_AREGS > 1) ? $clog2(NUM_AREGS) : 1
) (
    input  logic [AREG_W-1:0] sel,
    input  logic              tbl_valid [NUM_AREGS],
    input  logic [ROB_W-1:0]  tbl_idx   [NUM_AREGS],
    output logic              rd_valid,
    output logic [ROB_W-1:0]  rd_idx
);

    // Select the addressed entry and mask its index when unmapped.
    always_comb begin
        rd_valid = 1'b0;
        rd_idx   = '0;
        for (int r = 0; r < NUM_AREGS; r++) begin
            if (sel == AREG_W'(r) && tbl_valid[r]) begin
                rd_valid = 1'b1;
                rd_idx   = tbl_idx[r];
            end
        end
    end

endmodule

// File: rtl/rt_ckpt_store.sv
// Module rt_ckpt_store
// Keeps NUM_SLOTS full snapshots of the map. A save writes the supplied
// table into one slot; the restore slot is read out combinationally.
// Assumes: slot IDs at or above NUM_SLOTS are ignored on save and read as
// an all-unmapped table.
module rt_ckpt_store #(
    parameter int NUM_AREGS = 16,
    parameter int ROB_W     = 5,
    parameter int NUM_SLOTS = 2,
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              save,
    input  logic [SLOT_W-1:0] save_slot,
    input  logic [SLOT_W-1:0] rd_slot,
    input  logic              in_valid  [NUM_AREGS],
    input  logic [ROB_W-1:0]  in_idx    [NUM_AREGS],
    output logic              out_valid [NUM_AREGS],
    output logic [ROB_W-1:0]  out_idx   [NUM_AREGS]
);

    logic             snap_valid [NUM_SLOTS][NUM_AREGS];
    logic [ROB_W-1:0] snap_idx   [NUM_SLOTS][NUM_AREGS];

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        // Snapshot register for slot s, cleared on reset.
        always_ff @(posedge clk) begin
            for (int r = 0; r < NUM_AREGS; r++) begin
                if (!rst_n) begin
                    snap_valid[s][r] <= 1'b0;
                    snap_idx[s][r]   <= '0;
                end else if (save && save_slot == SLOT_W'(s)) begin
                    snap_valid[s][r] <= in_valid[r];
                    snap_idx[s][r]   <= in_idx[r];
                end
            end
        end
    end

    // Read out the slot selected for restore.
    always_comb begin
        for (int r = 0; r < NUM_AREGS; r++) begin
            out_valid[r] = 1'b0;
            out_idx[r]   = '0;
            for (int s = 0; s < NUM_SLOTS; s++) begin
                if (rd_slot == SLOT_W'(s)) begin
                    out_valid[r] = snap_valid[s][r];
                    out_idx[r]   = snap_idx[s][r];
                end
            end
        end
    end

endmodule

// File: rtl/rename_table.sv
// Module rename_table
// Register rename map with flush and snapshot recovery. Maps each
// architectural register to the reorder-buffer slot of its newest
// in-flight producer. Priority per entry: flush, restore, rename, retire.
// Assumes: one rename and one retire per cycle; CKPT_SLOTS=0 removes the
// snapshot store and makes save and restore no-ops.
module rename_table #(
    parameter int NUM_AREGS  = 16,
    parameter int ROB_W      = 5,
    parameter int CKPT_SLOTS = 2,
    localparam int AREG_W    = (NUM_AREGS > 1) ? $clog2(NUM_AREGS) : 1,
    localparam int SLOT_W    = (CKPT_SLOTS > 1) ? $clog2(CKPT_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ren_valid,
    input  logic              ren_dst_we,
    input  logic [AREG_W-1:0] ren_src_a,
    input  logic [AREG_W-1:0] ren_src_b,
    input  logic [AREG_W-1:0] ren_dst,
    input  logic [ROB_W-1:0]  ren_rob_idx,
    output logic              src_a_valid,
    output logic [ROB_W-1:0]  src_a_idx,
    output logic              src_b_valid,
    output logic [ROB_W-1:0]  src_b_idx,
    input  logic              cmt_valid,
    input  logic [AREG_W-1:0] cmt_dst,
    input  logic [ROB_W-1:0]  cmt_rob_idx,
    input  logic              flush,
    input  logic              ckpt_save,
    input  logic [SLOT_W-1:0] ckpt_save_slot,
    input  logic              ckpt_restore,
    input  logic [SLOT_W-1:0] ckpt_restore_slot
);

    logic             ren_we;
    logic             restore_eff;
    logic             cur_valid  [NUM_AREGS];
    logic [ROB_W-1:0] cur_idx    [NUM_AREGS];
    logic             nxt_valid  [NUM_AREGS];
    logic [ROB_W-1:0] nxt_idx    [NUM_AREGS];
    logic             snap_valid [NUM_AREGS];
    logic [ROB_W-1:0] snap_idx   [NUM_AREGS];

    assign ren_we = ren_valid && ren_dst_we;

    rt_map_store #(.NUM_AREGS(NUM_AREGS), .ROB_W(ROB_W)) u_map (
        .clk         (clk),
        .rst_n       (rst_n),
        .ren_we      (ren_we),
        .ren_dst     (ren_dst),
        .ren_rob_idx (ren_rob_idx),
        .cmt_valid   (cmt_valid),
        .cmt_dst     (cmt_dst),
        .cmt_rob_idx (cmt_rob_idx),
        .flush       (flush),
        .restore     (restore_eff),
        .load_valid  (snap_valid),
        .load_idx    (snap_idx),
        .cur_valid   (cur_valid),
        .cur_idx     (cur_idx),
        .nxt_valid   (nxt_valid),
        .nxt_idx     (nxt_idx)
    );

    rt_read_port #(.NUM_AREGS(NUM_AREGS), .ROB_W(ROB_W)) u_rd_a (
        .sel       (ren_src_a),
        .tbl_valid (cur_valid),
        .tbl_idx   (cur_idx),
        .rd_valid  (src_a_valid),
        .rd_idx    (src_a_idx)
    );

    rt_read_port #(.NUM_AREGS(NUM_AREGS), .ROB_W(ROB_W)) u_rd_b (
        .sel       (ren_src_b),
        .tbl_valid (cur_valid),
        .tbl_idx   (cur_idx),
        .rd_valid  (src_b_valid),
        .rd_idx    (src_b_idx)
    );

    if (CKPT_SLOTS > 0) begin : g_ckpt
        assign restore_eff = ckpt_restore;

        rt_ckpt_store #(.NUM_AREGS(NUM_AREGS), .ROB_W(ROB_W), .NUM_SLOTS(CKPT_SLOTS)) u_ckpt (
            .clk       (clk),
            .rst_n     (rst_n),
            .save      (ckpt_save),
            .save_slot (ckpt_save_slot),
            .rd_slot   (ckpt_restore_slot),
            .in_valid  (nxt_valid),
            .in_idx    (nxt_idx),
            .out_valid (snap_valid),
            .out_idx   (snap_idx)
        );
    end else begin : g_no_ckpt
        logic unused_ckpt;
        assign restore_eff = 1'b0;
        assign unused_ckpt = ckpt_save ^ (^ckpt_save_slot) ^ ckpt_restore ^ (^ckpt_restore_slot);
        // Empty snapshot table when no slots are built.
        always_comb begin
            for (int r = 0; r < NUM_AREGS; r++) begin
                snap_valid[r] = 1'b0;
                snap_idx[r]   = '0;
            end
        end
    end

    // R8: a restore without flush loads the selected snapshot for register 0 and the last one.
    a_r8_restore_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_eff && !flush) |=>
            ((cur_valid[0] == $past(snap_valid[0]))
             && (cur_valid[NUM_AREGS-1] == $past(snap_valid[NUM_AREGS-1]))
             && (!cur_valid[0] || cur_idx[0] == $past(snap_idx[0]))));

    // R2: an unmapped source never reports a producer index.
    a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !src_a_valid |-> (src_a_idx == '0));

endmodule

// File: tb/rename_table_test.sv
`timescale 1ns/1ps
module rename_table_test;

    localparam int NA = 16;
    localparam int RW = 5;
    localparam int AW = 4;
    localparam int NS = 2;

    typedef struct {
        logic          va;
        logic [RW-1:0] ia;
        logic          vb;
        logic [RW-1:0] ib;
        logic [AW-1:0] sa;
        logic [AW-1:0] sb;
        string         req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ren_valid = 0, ren_dst_we = 0;
    logic [AW-1:0] ren_src_a = 0, ren_src_b = 0, ren_dst = 0;
    logic [RW-1:0] ren_rob_idx = 0;
    logic src_a_valid, src_b_valid;
    logic [RW-1:0] src_a_idx, src_b_idx;
    logic cmt_valid = 0;
    logic [AW-1:0] cmt_dst = 0;
    logic [RW-1:0] cmt_rob_idx = 0;
    logic flush = 0, ckpt_save = 0, ckpt_restore = 0;
    logic [0:0] ckpt_save_slot = 0, ckpt_restore_slot = 0;

    int tests = 0;
    int fails = 0;
    bit done = 0;
    exp_t q[$];

    logic          mv [NA];
    logic [RW-1:0] mi [NA];
    logic          cv [NS][NA];
    logic [RW-1:0] ci [NS][NA];

    always #10 clk = ~clk;

    rename_table uut (
        .clk(clk), .rst_n(rst_n),
        .ren_valid(ren_valid), .ren_dst_we(ren_dst_we),
        .ren_src_a(ren_src_a), .ren_src_b(ren_src_b), .ren_dst(ren_dst),
        .ren_rob_idx(ren_rob_idx),
        .src_a_valid(src_a_valid), .src_a_idx(src_a_idx),
        .src_b_valid(src_b_valid), .src_b_idx(src_b_idx),
        .cmt_valid(cmt_valid), .cmt_dst(cmt_dst), .cmt_rob_idx(cmt_rob_idx),
        .flush(flush), .ckpt_save(ckpt_save), .ckpt_save_slot(ckpt_save_slot),
        .ckpt_restore(ckpt_restore), .ckpt_restore_slot(ckpt_restore_slot)
    );

    // Driver: one cycle of stimulus, expected lookup pushed, model advanced.
    task automatic step(input logic rv, input logic we, input int sa, input int sb,
                        input int d, input int ri, input logic cvld, input int cd,
                        input int cri, input logic fl, input logic sv, input int ss,
                        input logic rs, input int rsl, input string req);
        exp_t e;
        logic          nv [NA];
        logic [RW-1:0] ni [NA];
        @(negedge clk);
        ren_valid = rv; ren_dst_we = we;
        ren_src_a = AW'(sa); ren_src_b = AW'(sb); ren_dst = AW'(d);
        ren_rob_idx = RW'(ri);
        cmt_valid = cvld; cmt_dst = AW'(cd); cmt_rob_idx = RW'(cri);
        flush = fl; ckpt_save = sv; ckpt_save_slot = 1'(ss);
        ckpt_restore = rs; ckpt_restore_slot = 1'(rsl);
        e.sa = AW'(sa); e.sb = AW'(sb); e.req = req;
        e.va = mv[sa]; e.ia = mv[sa] ? mi[sa] : '0;
        e.vb = mv[sb]; e.ib = mv[sb] ? mi[sb] : '0;
        q.push_back(e);
        for (int r = 0; r < NA; r++) begin nv[r] = mv[r]; ni[r] = mi[r]; end
        if (cvld && mv[cd] && mi[cd] == RW'(cri)) nv[cd] = 1'b0;
        if (rv && we) begin nv[d] = 1'b1; ni[d] = RW'(ri); end
        if (rs) for (int r = 0; r < NA; r++) begin nv[r] = cv[rsl][r]; ni[r] = ci[rsl][r]; end
        if (fl) for (int r = 0; r < NA; r++) nv[r] = 1'b0;
        if (sv) for (int r = 0; r < NA; r++) begin cv[ss][r] = nv[r]; ci[ss][r] = ni[r]; end
        for (int r = 0; r < NA; r++) begin mv[r] = nv[r]; mi[r] = ni[r]; end
    endtask

    task automatic rd(input int sa, input int sb, input string req);
        step(0, 0, sa, sb, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, req);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    // Monitor: pops expectations and compares the lookup outputs.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                tests++;
                if (src_a_valid !== e.va || src_a_idx !== e.ia ||
                    src_b_valid !== e.vb || src_b_idx !== e.ib) begin
                    fails++;
                    $display("FAIL %s src %0d/%0d actual a=%b:%0d b=%b:%0d expected a=%b:%0d b=%b:%0d",
                             e.req, e.sa, e.sb, src_a_valid, src_a_idx, src_b_valid, src_b_idx,
                             e.va, e.ia, e.vb, e.ib);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(20ns * 200000);
        if (!done) begin
            tests++; fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < NA; r++) begin
            mv[r] = 0; mi[r] = 0;
            for (int s = 0; s < NS; s++) begin cv[s][r] = 0; ci[s][r] = 0; end
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state across all registers
        for (int r = 0; r < NA; r += 2) rd(r, r + 1, "R1");
        // R1: restore of an untouched slot yields an empty table
        step(1, 1, 0, 0, 9, 2, 0, 0, 0, 0, 0, 0, 0, 0, "R3");
        step(0, 0, 9, 9, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, "R3");
        rd(9, 0, "R1");
        // R3: rename maps the destination
        step(1, 1, 5, 2, 6, 3, 0, 0, 0, 0, 0, 0, 0, 0, "R3");
        rd(6, 5, "R3");
        // R3: no destination write changes nothing
        step(1, 0, 7, 6, 7, 4, 0, 0, 0, 0, 0, 0, 0, 0, "R3");
        rd(7, 6, "R3");
        // R4: same-cycle lookup sees the old mapping of the destination
        step(1, 1, 6, 6, 6, 9, 0, 0, 0, 0, 0, 0, 0, 0, "R4");
        rd(6, 7, "R4");
        // R5: stale retire ignored, matching retire clears
        step(0, 0, 6, 6, 0, 0, 1, 6, 3, 0, 0, 0, 0, 0, "R5");
        rd(6, 6, "R5");
        step(0, 0, 6, 6, 0, 0, 1, 6, 9, 0, 0, 0, 0, 0, "R5");
        rd(6, 6, "R5");
        // R6: rename and retire on one register, rename wins
        step(1, 1, 8, 0, 8, 10, 0, 0, 0, 0, 0, 0, 0, 0, "R6");
        step(1, 1, 8, 0, 8, 11, 1, 8, 10, 0, 0, 0, 0, 0, "R6");
        rd(8, 8, "R6");
        // R8: save captures the table including this cycle's rename
        step(1, 1, 1, 8, 1, 12, 0, 0, 0, 0, 1, 0, 0, 0, "R8");
        step(1, 1, 1, 2, 1, 13, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
        step(1, 1, 2, 8, 2, 14, 1, 8, 11, 0, 0, 0, 0, 0, "R8");
        rd(1, 2, "R8");
        step(1, 1, 3, 8, 3, 15, 0, 0, 0, 0, 0, 0, 1, 0, "R8");
        rd(1, 8, "R8");
        rd(2, 3, "R8");
        // R7: flush beats a same-cycle rename and restore
        step(1, 1, 4, 1, 4, 16, 1, 1, 12, 1, 0, 0, 1, 0, "R7");
        rd(4, 1, "R7");
        rd(8, 3, "R7");
        // R9: restore and save together, then flush and restore the new slot
        step(1, 1, 5, 0, 5, 17, 0, 0, 0, 0, 0, 0, 1, 0, "R9");
        rd(1, 5, "R9");
        step(0, 0, 1, 8, 0, 0, 0, 0, 0, 0, 1, 1, 1, 0, "R9");
        step(0, 0, 1, 8, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R9");
        rd(1, 8, "R7");
        step(0, 0, 1, 8, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, "R9");
        rd(1, 8, "R9");
        rd(5, 2, "R9");
        // R2: mixed traffic with lookups checked every cycle
        for (int k = 0; k < 80; k++) begin
            int a, b, d, c;
            a = $urandom % NA; b = $urandom % NA; d = $urandom % NA; c = $urandom % NA;
            step(1, (k % 5) != 0, a, b, d, k % 32, (k % 3) == 0, c, ($urandom % 4) + (k % 32) - 2,
                 (k % 23) == 22, (k % 11) == 4, k % 2, (k % 13) == 7, (k + 1) % 2, "R2");
        end
        for (int r = 0; r < NA; r += 2) rd(r, r + 1, "R2");
        rd(0, 0, "R2");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        summary();
        $finish;
    end

endmodule